// File: doc/BRIEF.md
# LVDS Lane Bit Mapper

This block turns one 28-bit source word per pixel period into serial bit streams on four data lanes and one clock lane of a single LVDS display channel. The source word carries 24 bits of colour in bits 23..0, horizontal sync in bit 24, vertical sync in bit 25 and data enable in bit 26. Bit 27 is reserved and always reads as zero. Every one of the seven bit slots on every data lane takes its bit from the source word through its own 5-bit index. These indices live in a table that a simple write port loads, one entry at a time, or all at once from a built-in preset for either colour depth.

The block runs on the fast bit clock. A bit-enable input marks the cycles that carry one serial bit, seven per pixel. A small sequencer holds the outputs quiet until the interface is enabled. It also waits until the serialize gate is opened, which software does only after the lanes and the table have been set up. Once running, it captures the source word at phase 0 of a 7-step phase count and shifts slot 6 out first, down to slot 0.

Sequencer states and transitions:
- `ST_IDLE`: the interface is off. It moves to `ST_ARMED` when the interface enable is set.
- `ST_ARMED`: the interface is on and the serialize gate is closed. It returns to `ST_IDLE` if the interface enable clears, and moves to `ST_RUN` when the serialize gate opens.
- `ST_RUN`: the block is shifting. It goes to `ST_IDLE` if the interface enable clears, or to `ST_ARMED` if the serialize gate closes.

In every state other than `ST_RUN`, the shift registers and the phase count are cleared.

Top module: `lvds_lane_mapper`

## Requirements
- R1: After reset, all outputs are 0, the sequencer is idle, and the table holds the 24-bit preset. That preset is, listed per lane from slot 0 to slot 6: lane 0 = 08,05,04,03,02,01,00; lane 1 = 11,10,0D,0C,0B,0A,09; lane 2 = 1A,19,18,15,14,13,12; lane 3 = 1B,17,16,0F,0E,07,06 (hex).
- R2: While `if_en_i` is 0, then from the next clock on every data bit, `clk_o` and `rgb_mode_o` are 0.
- R3: While `ser_en_i` is 0, then from the next clock on every data bit and `clk_o` are 0. This also holds when the gate closes in the middle of a pixel.
- R4: In `ST_RUN`, the source word is captured on the bit-enable cycle at phase 0. Slot 6 appears on the outputs after that edge, and each later bit-enable cycle presents the next lower slot. A cycle without bit enable holds both the outputs and the phase. A change of the source word away from phase 0 has no effect on the word being sent.
- R5: The bit sent in slot s of lane l is bit `idx` of the source word, where `idx` is the table entry for lane l, slot s. An index of 27 or more gives 0.
- R6: A write pulse on `tbl_we_i` stores `tbl_val_i` into the entry at (`tbl_lane_i`, `tbl_slot_i`). A slot index of 7 changes nothing.
- R7: A pulse on `tbl_preset_i` loads the whole table with the preset for the current mode. The preset overrides a write in the same cycle. The 24-bit preset is given in R1. The 18-bit preset, per lane from slot 0 to slot 6, is: lane 0 = 0A,07,06,05,04,03,02; lane 1 = 13,12,0F,0E,0D,0C,0B; lane 2 = 1A,19,18,17,16,15,14; lane 3 = all 1B.
- R8: With `mode24_i` = 1, four data lanes are active. With `mode24_i` = 0, logical lane 3 always sends 0, and `rgb_mode_o` is 1 whenever the sequencer is not idle.
- R9: `lane_en_i[l]` = 0 forces logical lane l to 0 at once, and `clk_lane_en_i` = 0 forces `clk_o` to 0 at once.
- R10: The clock lane sends the pattern 1100011 every pixel period, most significant bit first, in step with slots 6..0. So the clock bit for slot s is bit s of that pattern.
- R11: With `swap_i` = 1, output pin p carries logical lane 3-p. With `swap_i` = 0, pin p carries lane p.
- R12: The phase stays in 0..6. After the bit-enable cycle at phase 6, the next bit-enable cycle captures a new source word with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a serial-bit cycle |
| pix_i | input | 28 | Source word: RGB 23..0, hsync 24, vsync 25, data enable 26, reserved 27 |
| mode24_i | input | 1 | 1 = 24-bit mode (four lanes), 0 = 18-bit mode (three lanes) |
| if_en_i | input | 1 | Interface enable |
| ser_en_i | input | 1 | Serialize gate |
| lane_en_i | input | 4 | Per-lane enable for logical data lanes |
| clk_lane_en_i | input | 1 | Clock lane enable |
| swap_i | input | 1 | Reverse the order of the data lane pins |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_lane_i | input | 2 | Lane of the entry being written |
| tbl_slot_i | input | 3 | Slot of the entry being written (7 is ignored) |
| tbl_val_i | input | 5 | Source index to store |
| tbl_preset_i | input | 1 | Load the preset for the current mode |
| data_o | output | 4 | Serial data lane bits |
| clk_o | output | 1 | Serial clock lane bit |
| rgb_mode_o | output | 1 | 18-bit RGB output mode flag |

## Verification
Some properties are checked by assertions on every cycle:
- the quiet outputs that follow a closed serialize gate or a cleared interface enable,
- the bounds and wrap of the phase count,
- the phase holding still on cycles without bit enable,
- the first clock-lane bit after a capture,
- the blanking of lane 3 in 18-bit mode and of a disabled lane 0.

Other behaviour needs the bench's sweeps, because it depends on stored table contents and on the data:
- the mapping of every slot to its source bit, under both presets, walking-one words and many written tables,
- that a reserved index reads as zero,
- the lane-mask and swap combinations,
- back-to-back capture.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;
    localparam int LANES    = 4;
    localparam int SLOTS    = 7;
    localparam int IDX_W    = 5;
    localparam int SRC_W    = 28;
    localparam int RSVD_IDX = 27;
    localparam int LANE_W   = $clog2(LANES);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef idx_t [SLOTS-1:0]   lane_map_t;
    typedef lane_map_t [LANES-1:0] map_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} seq_state_t;

    // Concatenations list slot 6 first, slot 0 last.
    function automatic map_t preset_map(input logic wide);
        map_t m;
        if (wide) begin
            m[0] = {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h08};
            m[1] = {5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h10, 5'h11};
            m[2] = {5'h12, 5'h13, 5'h14, 5'h15, 5'h18, 5'h19, 5'h1A};
            m[3] = {5'h06, 5'h07, 5'h0E, 5'h0F, 5'h16, 5'h17, 5'h1B};
        end else begin
            m[0] = {5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h0A};
            m[1] = {5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h0F, 5'h12, 5'h13};
            m[2] = {5'h14, 5'h15, 5'h16, 5'h17, 5'h18, 5'h19, 5'h1A};
            m[3] = {SLOTS{5'h1B}};
        end
        return m;
    endfunction
endpackage

// File: rtl/lvds_map_table.sv
module lvds_map_table
    import lvds_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_val,
    input  logic              preset,
    input  logic              mode24,
    output map_t              map_o
);
    map_t map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= preset_map(1'b1);
        end else if (preset) begin
            map_q <= preset_map(mode24);
        end else if (we && (int'(wr_slot) < SLOTS)) begin
            map_q[wr_lane][wr_slot] <= wr_val;
        end
    end

    assign map_o = map_q;
endmodule

// File: rtl/lvds_seq_ctrl.sv
module lvds_seq_ctrl
    import lvds_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              ser_en,
    input  logic              bit_en,
    output seq_state_t        state_o,
    output logic [SLOT_W-1:0] phase_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              clear_o
);
    localparam logic [SLOT_W-1:0] LAST_PHASE = SLOT_W'(SLOTS - 1);

    seq_state_t        state, nxt;
    logic [SLOT_W-1:0] phase;
    logic              run_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (if_en) nxt = ST_ARMED;
            ST_ARMED: if (!if_en) nxt = ST_IDLE;
                      else if (ser_en) nxt = ST_RUN;
            ST_RUN:   if (!if_en) nxt = ST_IDLE;
                      else if (!ser_en) nxt = ST_ARMED;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        run_ok  = (state == ST_RUN) && (nxt == ST_RUN);
        load_o  = run_ok && bit_en && (phase == '0);
        shift_o = run_ok && bit_en && (phase != '0);
        clear_o = (nxt != ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phase <= '0;
        else if (clear_o)          phase <= '0;
        else if (run_ok && bit_en) phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
    end

    assign state_o = state;
    assign phase_o = phase;
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
    import lvds_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] pix,
    input  map_t             map_i,
    input  logic             mode24,
    input  logic [LANES-1:0] lane_en,
    input  logic             clk_lane_en,
    input  logic             load,
    input  logic             shift,
    input  logic             clear,
    output logic [LANES-1:0] lane_bits,
    output logic             clk_bit
);
    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0]  src_ext;
    logic [SLOTS-1:0] clk_sr;

    assign src_ext = SPAN'(pix) & ~(SPAN'(1) << RSVD_IDX);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] word;
        logic [SLOTS-1:0] sr;
        logic             active;

        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign word[s] = src_ext[map_i[l][s]];
        end

        assign active = lane_en[l] && (mode24 || (l < LANES - 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr <= '0;
            else if (clear) sr <= '0;
            else if (load)  sr <= word;
            else if (shift) sr <= {sr[SLOTS-2:0], 1'b0};
        end

        assign lane_bits[l] = sr[SLOTS-1] & active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     clk_sr <= '0;
        else if (clear) clk_sr <= '0;
        else if (load)  clk_sr <= CLK_PATTERN;
        else if (shift) clk_sr <= {clk_sr[SLOTS-2:0], 1'b0};
    end

    assign clk_bit = clk_sr[SLOTS-1] & clk_lane_en;
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
    import lvds_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic [27:0] pix_i,
    input  logic        mode24_i,
    input  logic        if_en_i,
    input  logic        ser_en_i,
    input  logic [3:0]  lane_en_i,
    input  logic        clk_lane_en_i,
    input  logic        swap_i,
    input  logic        tbl_we_i,
    input  logic [1:0]  tbl_lane_i,
    input  logic [2:0]  tbl_slot_i,
    input  logic [4:0]  tbl_val_i,
    input  logic        tbl_preset_i,
    output logic [3:0]  data_o,
    output logic        clk_o,
    output logic        rgb_mode_o
);
    map_t              map_w;
    seq_state_t        state_w;
    logic [SLOT_W-1:0] phase_w;
    logic              load_w, shift_w, clear_w;
    logic [LANES-1:0]  lane_bits_w;

    lvds_map_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we_i),
        .wr_lane (tbl_lane_i),
        .wr_slot (tbl_slot_i),
        .wr_val  (tbl_val_i),
        .preset  (tbl_preset_i),
        .mode24  (mode24_i),
        .map_o   (map_w)
    );

    lvds_seq_ctrl u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .if_en   (if_en_i),
        .ser_en  (ser_en_i),
        .bit_en  (bit_en),
        .state_o (state_w),
        .phase_o (phase_w),
        .load_o  (load_w),
        .shift_o (shift_w),
        .clear_o (clear_w)
    );

    lvds_lane_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix         (pix_i),
        .map_i       (map_w),
        .mode24      (mode24_i),
        .lane_en     (lane_en_i),
        .clk_lane_en (clk_lane_en_i),
        .load        (load_w),
        .shift       (shift_w),
        .clear       (clear_w),
        .lane_bits   (lane_bits_w),
        .clk_bit     (clk_o)
    );

    for (genvar p = 0; p < LANES; p++) begin : g_pin
        assign data_o[p] = swap_i ? lane_bits_w[LANES-1-p] : lane_bits_w[p];
    end

    assign rgb_mode_o = (state_w != ST_IDLE) && !mode24_i;
endmodule

// File: rtl/lvds_lane_mapper_chk.sv
module lvds_lane_mapper_chk
    import lvds_map_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              if_en,
    input logic              ser_en,
    input logic              mode24,
    input logic              swap,
    input logic              lane_en0,
    input logic              clk_lane_en,
    input seq_state_t        state,
    input logic [SLOT_W-1:0] phase,
    input logic [3:0]        data,
    input logic              clk_bit,
    input logic              rgb_mode
);
    logic running;
    assign running = (state == ST_RUN) && if_en && ser_en;

    a_r3_quiet_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> (data == 4'b0 && !clk_bit));

    a_r2_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> (data == 4'b0 && !clk_bit && !rgb_mode));

    a_r12_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < SLOTS);

    a_r12_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bit_en && int'(phase) == SLOTS - 1) |=> (phase == '0));

    a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !bit_en) |=> $stable(phase));

    a_r10_clock_first: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bit_en && phase == '0) |=> (clk_bit || !clk_lane_en));

    a_r8_lane3_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode24 && !swap) |-> !data[3]);

    a_r9_lane0_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_en0 && !swap) |-> !data[0]);
endmodule

bind lvds_lane_mapper lvds_lane_mapper_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .if_en       (if_en_i),
    .ser_en      (ser_en_i),
    .mode24      (mode24_i),
    .swap        (swap_i),
    .lane_en0    (lane_en_i[0]),
    .clk_lane_en (clk_lane_en_i),
    .state       (state_w),
    .phase       (phase_w),
    .data        (data_o),
    .clk_bit     (clk_o),
    .rgb_mode    (rgb_mode_o)
);

// File: tb/lvds_lane_mapper_tb.sv
module lvds_lane_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [27:0] pix = '0;
    logic        mode24 = 1'b1;
    logic        if_en = 1'b0;
    logic        ser_en = 1'b0;
    logic [3:0]  lane_en = 4'hF;
    logic        clk_lane_en = 1'b1;
    logic        swap = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_lane = '0;
    logic [2:0]  tbl_slot = '0;
    logic [4:0]  tbl_val = '0;
    logic        tbl_preset = 1'b0;
    logic [3:0]  data_o;
    logic        clk_o;
    logic        rgb_mode_o;

    int n_chk = 0;
    int n_err = 0;
    logic [4:0] mdl [4][7];
    localparam logic [6:0] CPAT = 7'b1100011;

    always #2 clk = ~clk;

    lvds_lane_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pix_i(pix),
        .mode24_i(mode24), .if_en_i(if_en), .ser_en_i(ser_en),
        .lane_en_i(lane_en), .clk_lane_en_i(clk_lane_en), .swap_i(swap),
        .tbl_we_i(tbl_we), .tbl_lane_i(tbl_lane), .tbl_slot_i(tbl_slot),
        .tbl_val_i(tbl_val), .tbl_preset_i(tbl_preset),
        .data_o(data_o), .clk_o(clk_o), .rgb_mode_o(rgb_mode_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_preset(input logic wide);
        int v24 [4][7] = '{'{8,5,4,3,2,1,0}, '{17,16,13,12,11,10,9},
                           '{26,25,24,21,20,19,18}, '{27,23,22,15,14,7,6}};
        int v18 [4][7] = '{'{10,7,6,5,4,3,2}, '{19,18,15,14,13,12,11},
                           '{26,25,24,23,22,21,20}, '{27,27,27,27,27,27,27}};
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 7; s++)
                mdl[l][s] = wide ? 5'(v24[l][s]) : 5'(v18[l][s]);
    endtask

    function automatic logic [4:0] exp_slot(input logic [27:0] p, input int s);
        logic [4:0] r = '0;
        for (int q = 0; q < 4; q++) begin
            int l = swap ? 3 - q : q;
            int ix = int'(mdl[l][s]);
            if (lane_en[l] && if_en && (mode24 || l < 3) && ix < 27) r[q] = p[ix];
        end
        r[4] = clk_lane_en && if_en && CPAT[s];
        return r;
    endfunction

    task automatic preset(input logic wide);
        @(negedge clk); mode24 = wide; tbl_preset = 1'b1;
        @(negedge clk); tbl_preset = 1'b0;
        model_preset(wide);
    endtask

    task automatic wr(input int l, input int s, input int v);
        @(negedge clk); tbl_we = 1'b1; tbl_lane = 2'(l); tbl_slot = 3'(s); tbl_val = 5'(v);
        @(negedge clk); tbl_we = 1'b0;
        if (s < 7) mdl[l][s] = 5'(v);
    endtask

    task automatic run_frame(input logic [27:0] p, input bit gap, input string tag);
        @(negedge clk); ser_en = 1'b0; pix = p; bit_en = 1'b1;
        @(negedge clk); ser_en = 1'b1;
        @(negedge clk);
        for (int s = 6; s >= 0; s--) begin
            bit_en = 1'b1;
            @(negedge clk);
            check(tag, {27'b0, clk_o, data_o}, {27'b0, exp_slot(p, s)});
            if (gap) begin
                bit_en = 1'b0;
                @(negedge clk);
                check({tag, " R4 hold"}, {27'b0, clk_o, data_o}, {27'b0, exp_slot(p, s)});
            end
        end
        bit_en = 1'b1;
    endtask

    // R12 back-to-back words; R4 source changes away from phase 0 are ignored
    task automatic run_stream(input logic [27:0] p1, input logic [27:0] p2);
        @(negedge clk); ser_en = 1'b0; pix = p1; bit_en = 1'b1;
        @(negedge clk); ser_en = 1'b1;
        @(negedge clk);
        for (int s = 6; s >= 0; s--) begin
            @(negedge clk);
            check("R4 R12 first word", {27'b0, clk_o, data_o}, {27'b0, exp_slot(p1, s)});
            if (s == 3) pix = ~p1;
            if (s == 0) pix = p2;
        end
        for (int s = 6; s >= 0; s--) begin
            @(negedge clk);
            check("R12 second word", {27'b0, clk_o, data_o}, {27'b0, exp_slot(p2, s)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [27:0] lf;
        model_preset(1'b1);
        repeat (4) @(negedge clk);
        check("R1 reset outputs", {26'b0, rgb_mode_o, clk_o, data_o}, 32'h0);
        rst_n = 1'b1;

        // R2: interface off
        @(negedge clk); if_en = 1'b0; ser_en = 1'b1; bit_en = 1'b1; pix = '1; mode24 = 1'b0;
        repeat (12) begin
            @(negedge clk);
            check("R2 off quiet", {26'b0, rgb_mode_o, clk_o, data_o}, 32'h0);
        end
        // R3: gate closed
        if_en = 1'b1; ser_en = 1'b0;
        repeat (12) begin
            @(negedge clk);
            check("R3 gate closed", {27'b0, clk_o, data_o}, 32'h0);
        end
        check("R8 rgb flag 18", {31'b0, rgb_mode_o}, 32'h1);
        mode24 = 1'b1;
        @(negedge clk);
        check("R8 rgb flag 24", {31'b0, rgb_mode_o}, 32'h0);

        // R1 R5: reset table, walking one
        for (int b = 0; b < 28; b++) run_frame(28'(1) << b, 1'b0, "R1 R5 reset map");
        run_frame('1, 1'b0, "R1 R5 all ones");

        // R7 R8: 18-bit preset
        preset(1'b0);
        for (int b = 0; b < 28; b++) run_frame(28'(1) << b, 1'b0, "R7 R8 preset18");
        run_frame('1, 1'b0, "R8 lane3 blank");
        preset(1'b1);
        for (int b = 0; b < 28; b++) run_frame(28'(1) << b, 1'b0, "R7 preset24");

        // R6 R5: written tables incl. reserved indices
        lf = 28'h5A3C1E7;
        for (int k = 0; k < 4; k++) begin
            for (int l = 0; l < 4; l++)
                for (int s = 0; s < 7; s++) wr(l, s, (l * 7 + s + k * 9) % 32);
            for (int b = 0; b < 28; b++) run_frame(28'(1) << b, 1'b0, "R5 R6 written map");
            for (int n = 0; n < 6; n++) begin
                lf = {lf[26:0], lf[27] ^ lf[24]};
                run_frame(lf, 1'b0, "R5 R6 pattern");
            end
        end
        wr(0, 7, 0);
        run_frame('1, 1'b0, "R6 slot7 ignored");
        // R7: preset beats write in same cycle
        @(negedge clk); mode24 = 1'b1; tbl_preset = 1'b1; tbl_we = 1'b1;
        tbl_lane = 2'd0; tbl_slot = 3'd6; tbl_val = 5'd27;
        @(negedge clk); tbl_preset = 1'b0; tbl_we = 1'b0; model_preset(1'b1);
        run_frame(28'h0000001, 1'b0, "R7 preset priority");

        // R9 R11: masks and swap
        for (int sw = 0; sw < 2; sw++)
            for (int m = 0; m < 16; m++) begin
                swap = sw[0]; lane_en = 4'(m);
                run_frame(28'hFFFFFFF, 1'b0, "R9 R11 mask swap");
                run_frame(28'h0F0F0F0, 1'b0, "R11 swap data");
            end
        swap = 1'b0; lane_en = 4'hF;
        // R9: immediate blanking while running
        run_frame(28'hFFFFFFF, 1'b0, "R9 base");
        @(negedge clk); lane_en = 4'h0; clk_lane_en = 1'b0;
        @(negedge clk); bit_en = 1'b0;
        check("R9 immediate blank", {27'b0, clk_o, data_o}, 32'h0);
        lane_en = 4'hF;
        // R10: clock lane off and on
        run_frame(28'h0000000, 1'b0, "R10 clock off");
        clk_lane_en = 1'b1;
        run_frame(28'h0000000, 1'b0, "R10 clock pattern");

        // R4: bit enable gaps
        run_frame(28'hA5C3F01, 1'b1, "R4 gapped");
        preset(1'b0);
        run_frame(28'h3FFFFFF, 1'b1, "R4 gapped 18");
        preset(1'b1);

        // R12: streaming
        run_stream(28'h1234567, 28'h7654321);
        run_stream(28'h0FFFFFF, 28'h5555555);

        // R3: gate closes mid-pixel
        run_frame(28'hFFFFFFF, 1'b0, "R3 pre");
        @(negedge clk); ser_en = 1'b0;
        @(negedge clk);
        check("R3 mid-pixel stop", {27'b0, clk_o, data_o}, 32'h0);
        // R2: interface off while running
        ser_en = 1'b1;
        run_frame(28'hFFFFFFF, 1'b0, "R2 pre");
        @(negedge clk); if_en = 1'b0; mode24 = 1'b0;
        @(negedge clk);
        check("R2 stop from run", {26'b0, rgb_mode_o, clk_o, data_o}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule